// File: doc/BRIEF.md
# Acquisition Sequencer for a Strip-Detector Front End

This block sequences the digital side of a multi-channel strip readout. A four-state machine moves through four phases. In IDLE it waits and can be set up. In ACQUIRE it streams samples into a circular 8-row by 8-column analogue store at a programmable rate. In CONVERT it freezes that store and lets the digitiser run. In READOUT it holds the result until downstream logic has taken it.

Captures are started by a trigger. The trigger comes from one of two selectable sources: the per-channel threshold detector, or an external digital line. Each capture receives an event number. A time stamp counts the samples written. A trigger that arrives outside ACQUIRE is not lost silently: it is counted in a saturating counter. A calibration pulse, with a 10-bit amplitude code, can be fired on entry into acquisition.

The transitions are named as follows:
- IDLE→ACQUIRE on `start_i`.
- ACQUIRE→IDLE on `stop_i`.
- ACQUIRE→CONVERT on a selected trigger.
- CONVERT→READOUT on `conv_done_i`.
- READOUT→ACQUIRE on `rd_ack_i` when `rearm_i` is high.
- READOUT→IDLE on `rd_ack_i` when `rearm_i` is low.

Top module: `acq_ctrl`

## Requirements
- R1: After reset, `state_o` is IDLE (encoding IDLE=0, ACQUIRE=1, CONVERT=2, READOUT=3). The write cell is row 0 / column 0, and time stamp, event number and missed count are 0. `wr_en_o`, `conv_start_o` and `cal_pulse_o` are low.
- R2: `start_i` in IDLE gives ACQUIRE on the next cycle. `stop_i` in ACQUIRE with no selected trigger gives IDLE on the next cycle. A write that falls in the stop cycle still completes.
- R3: In ACQUIRE, `wr_en_o` is high once every `rate_i`+1 cycles. The first write is `rate_i` cycles after ACQUIRE is entered, counting the entry cycle as cycle 0.
- R4: Each write advances the cell index by one, modulo 64, and the index wraps from 63 to 0. The index equals `wr_row_o`*8 + `wr_col_o`. Without a write, the index holds.
- R5: `time_stamp_o` increases by one for each write.
- R6: `trig_mode_i`=0 selects `trig_int_i` and `trig_mode_i`=1 selects `trig_ext_i`. A selected trigger in ACQUIRE gives CONVERT on the next cycle and increments `event_id_o`, which wraps from 255 to 0. The unselected line has no effect.
- R7: `wr_en_o` is never high outside ACQUIRE. In CONVERT, `rd_row_o`/`rd_col_o` name the last cell written.
- R8: `conv_start_o` is high for exactly the first CONVERT cycle. The state remains CONVERT until `conv_done_i` is high.
- R9: The state remains READOUT until `rd_ack_i` is high. It then goes to ACQUIRE if `rearm_i` is high, and to IDLE otherwise.
- R10: A selected trigger in any state other than ACQUIRE increments `miss_cnt_o`, which saturates at 15.
- R11: On every entry into ACQUIRE, `cal_amp_o` takes `cal_amp_i`. `cal_pulse_o` is high for the first ACQUIRE cycle only, and only if `cal_en_i` was high at entry.
- R12: A selected trigger and `stop_i` in the same ACQUIRE cycle give CONVERT, and the event is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin acquisition from IDLE |
| stop_i | input | 1 | Abort acquisition back to IDLE |
| rearm_i | input | 1 | After readout, return to ACQUIRE instead of IDLE |
| trig_mode_i | input | 1 | Trigger source select: 0 internal, 1 external |
| trig_int_i | input | 1 | Threshold-detector trigger |
| trig_ext_i | input | 1 | External trigger line |
| rate_i | input | 8 | Sample period minus one, in clock cycles |
| cal_en_i | input | 1 | Fire a calibration pulse on entering ACQUIRE |
| cal_amp_i | input | 10 | Calibration amplitude code |
| conv_done_i | input | 1 | Digitiser finished |
| rd_ack_i | input | 1 | Readout has taken the data |
| state_o | output | 2 | Current state |
| wr_en_o | output | 1 | Sample write strobe for the store |
| wr_row_o | output | 3 | Row of the cell to write |
| wr_col_o | output | 3 | Column of the cell to write |
| rd_row_o | output | 3 | Row of the newest written cell |
| rd_col_o | output | 3 | Column of the newest written cell |
| conv_start_o | output | 1 | One-cycle digitiser start |
| cal_pulse_o | output | 1 | One-cycle calibration pulse |
| cal_amp_o | output | 10 | Latched calibration amplitude |
| time_stamp_o | output | 16 | Sample count time tag |
| event_id_o | output | 8 | Event number |
| miss_cnt_o | output | 4 | Saturating missed-trigger count |

## Verification
Three pairs of functions can fall in the same cycle:
- A selected trigger and a sample write. The bench runs at `rate_i`=0, raises the trigger, and checks that the cell is still written, the pointer and stamp have advanced, and the newest-cell output names that cell in CONVERT.
- A trigger and `stop_i`. These are raised together, and the bench expects CONVERT with the event counted.
- A stop and a sample write. The bench expects the write to land before IDLE is reached.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_READ = 2'd3
    } acq_state_t;
endpackage

// File: rtl/acq_rate_div.sv
module acq_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] period_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q >= period_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/acq_cell_ptr.sv
module acq_cell_ptr #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int TS_W = 16,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic [TS_W-1:0]  stamp_o
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [TS_W-1:0]  stamp_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            row_q   <= '0;
            col_q   <= '0;
            stamp_q <= '0;
        end else if (adv_i) begin
            stamp_q <= stamp_q + TS_W'(1);
            if (col_q == COL_LAST) begin
                col_q <= '0;
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    assign row_o   = row_q;
    assign col_o   = col_q;
    assign stamp_o = stamp_q;

    // R4: column steps by one inside a row
    a_r4_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && col_q != COL_LAST) |=> (col_q == $past(col_q) + COL_W'(1) && row_q == $past(row_q)));
    // R4: no write, no movement
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> ($stable(col_q) && $stable(row_q)));
    // R5: stamp follows writes
    a_r5_stamp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> stamp_q == $past(stamp_q) + TS_W'(1));
endmodule

// File: rtl/acq_sat_cnt.sv
module acq_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != TOP) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R10: saturation holds
    a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q == TOP |=> cnt_q == TOP);
    // R10: each miss below the top is counted
    a_r10_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int TS_W   = 16,
    parameter int EV_W   = 8,
    parameter int MISS_W = 4,
    parameter int DIV_W  = 8,
    parameter int CAL_W  = 10
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     rearm_i,
    input  logic                     trig_mode_i,
    input  logic                     trig_int_i,
    input  logic                     trig_ext_i,
    input  logic [DIV_W-1:0]         rate_i,
    input  logic                     cal_en_i,
    input  logic [CAL_W-1:0]         cal_amp_i,
    input  logic                     conv_done_i,
    input  logic                     rd_ack_i,
    output logic [1:0]               state_o,
    output logic                     wr_en_o,
    output logic [$clog2(ROWS)-1:0]  wr_row_o,
    output logic [$clog2(COLS)-1:0]  wr_col_o,
    output logic [$clog2(ROWS)-1:0]  rd_row_o,
    output logic [$clog2(COLS)-1:0]  rd_col_o,
    output logic                     conv_start_o,
    output logic                     cal_pulse_o,
    output logic [CAL_W-1:0]         cal_amp_o,
    output logic [TS_W-1:0]          time_stamp_o,
    output logic [EV_W-1:0]          event_id_o,
    output logic [MISS_W-1:0]        miss_cnt_o
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    acq_state_t state_q, state_d;
    logic       trig_sel, tick, in_acq, enter_acq, enter_conv;
    logic [EV_W-1:0]  event_q;
    logic             conv_start_q, cal_pulse_q;
    logic [CAL_W-1:0] cal_amp_q;
    logic [ROW_W-1:0] row_w;
    logic [COL_W-1:0] col_w;

    assign trig_sel   = trig_mode_i ? trig_ext_i : trig_int_i;
    assign in_acq     = (state_q == ST_ACQ);
    assign enter_acq  = (state_d == ST_ACQ) && !in_acq;
    assign enter_conv = (state_d == ST_CONV) && in_acq;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)     state_d = ST_ACQ;
            ST_ACQ: begin
                if (trig_sel)         state_d = ST_CONV;
                else if (stop_i)      state_d = ST_IDLE;
            end
            ST_CONV: if (conv_done_i) state_d = ST_READ;
            ST_READ: if (rd_ack_i)    state_d = rearm_i ? ST_ACQ : ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            event_q      <= '0;
            conv_start_q <= 1'b0;
            cal_pulse_q  <= 1'b0;
            cal_amp_q    <= '0;
        end else begin
            conv_start_q <= enter_conv;
            cal_pulse_q  <= enter_acq && cal_en_i;
            if (enter_acq)  cal_amp_q <= cal_amp_i;
            if (enter_conv) event_q   <= event_q + EV_W'(1);
        end
    end

    acq_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (in_acq),
        .period_i (rate_i),
        .tick_o   (tick)
    );

    acq_cell_ptr #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) u_ptr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (wr_en_o),
        .row_o   (row_w),
        .col_o   (col_w),
        .stamp_o (time_stamp_o)
    );

    acq_sat_cnt #(.W(MISS_W)) u_miss (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (trig_sel && !in_acq),
        .cnt_o  (miss_cnt_o)
    );

    // newest written cell is the one before the write pointer
    always_comb begin
        if (col_w == '0) begin
            rd_col_o = COL_W'(COLS - 1);
            rd_row_o = (row_w == '0) ? ROW_W'(ROWS - 1) : row_w - ROW_W'(1);
        end else begin
            rd_col_o = col_w - COL_W'(1);
            rd_row_o = row_w;
        end
    end

    assign wr_en_o      = tick && in_acq;
    assign wr_row_o     = row_w;
    assign wr_col_o     = col_w;
    assign state_o      = state_q;
    assign conv_start_o = conv_start_q;
    assign cal_pulse_o  = cal_pulse_q;
    assign cal_amp_o    = cal_amp_q;
    assign event_id_o   = event_q;

    // R8: convert is held until the digitiser reports done
    a_r8_conv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CONV && !conv_done_i) |=> state_q == ST_CONV);
    // R8: start strobe lasts one cycle and only in convert
    a_r8_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_start_q |-> (state_q == ST_CONV) ##1 !conv_start_q);
    // R9: readout is held until acknowledged
    a_r9_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_READ && !rd_ack_i) |=> state_q == ST_READ);
    // R6: entering convert counts one event
    a_r6_event_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CONV && $past(state_q) == ST_ACQ) |-> event_q == $past(event_q) + EV_W'(1));
    // R11: calibration pulse only on the first acquire cycle
    a_r11_cal_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_pulse_q |-> (state_q == ST_ACQ && $past(state_q) != ST_ACQ));
endmodule

// File: tb/acq_ctrl_tb_top.sv
module acq_ctrl_tb_top;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start_i = 0, stop_i = 0, rearm_i = 0, trig_mode_i = 0;
    logic       trig_int_i = 0, trig_ext_i = 0, cal_en_i = 0;
    logic       conv_done_i = 0, rd_ack_i = 0;
    logic [7:0] rate_i = 0;
    logic [9:0] cal_amp_i = 0;
    logic [1:0] state_o;
    logic       wr_en_o, conv_start_o, cal_pulse_o;
    logic [2:0] wr_row_o, wr_col_o, rd_row_o, rd_col_o;
    logic [9:0] cal_amp_o;
    logic [15:0] time_stamp_o;
    logic [7:0] event_id_o;
    logic [3:0] miss_cnt_o;

    int checks = 0, errors = 0;
    int eptr = 0, estamp = 0, eev = 0, emiss = 0;

    always #10 clk = ~clk;

    acq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
        .rearm_i(rearm_i), .trig_mode_i(trig_mode_i), .trig_int_i(trig_int_i),
        .trig_ext_i(trig_ext_i), .rate_i(rate_i), .cal_en_i(cal_en_i),
        .cal_amp_i(cal_amp_i), .conv_done_i(conv_done_i), .rd_ack_i(rd_ack_i),
        .state_o(state_o), .wr_en_o(wr_en_o), .wr_row_o(wr_row_o),
        .wr_col_o(wr_col_o), .rd_row_o(rd_row_o), .rd_col_o(rd_col_o),
        .conv_start_o(conv_start_o), .cal_pulse_o(cal_pulse_o),
        .cal_amp_o(cal_amp_o), .time_stamp_o(time_stamp_o),
        .event_id_o(event_id_o), .miss_cnt_o(miss_cnt_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_ptr(input string tag);
        chk({tag, " row"}, wr_row_o, eptr / 8);
        chk({tag, " col"}, wr_col_o, eptr % 8);
        chk({tag, " stamp R5"}, time_stamp_o, estamp);
    endtask

    task automatic test_reset();
        chk("R1 state", state_o, 0);
        chk("R1 wr_en", wr_en_o, 0);
        chk("R1 event", event_id_o, 0);
        chk("R1 miss", miss_cnt_o, 0);
        chk("R1 conv_start", conv_start_o, 0);
        chk("R1 cal_pulse", cal_pulse_o, 0);
        chk_ptr("R1");
    endtask

    task automatic test_rate_stop();
        rate_i = 8'd2; cal_en_i = 1; cal_amp_i = 10'h2A5; start_i = 1;
        step();
        start_i = 0; cal_en_i = 0;
        chk("R2 enter acquire", state_o, 1);
        chk("R11 cal pulse", cal_pulse_o, 1);
        chk("R11 cal amp", cal_amp_o, 10'h2A5);
        for (int k = 0; k < 12; k++) begin
            chk("R3 write cadence", wr_en_o, (k % 3 == 2) ? 1 : 0);
            if (k == 1) chk("R11 cal pulse ends", cal_pulse_o, 0);
            if (k % 3 == 2) begin eptr = (eptr + 1) % 64; estamp++; end
            step();
        end
        chk_ptr("R4 after cadence");
        chk("R2 stop cycle no write", wr_en_o, 0);
        stop_i = 1;
        step();
        stop_i = 0;
        chk("R2 stop to idle", state_o, 0);
        for (int k = 0; k < 3; k++) begin
            chk("R7 idle no write", wr_en_o, 0);
            step();
        end
        chk_ptr("R4 idle hold");
        chk("R6 no event on stop", event_id_o, eev);
    endtask

    task automatic test_int_trigger();
        trig_mode_i = 0; rate_i = 0; rearm_i = 0; start_i = 1;
        step();
        start_i = 0;
        chk("R3 rate0 write", wr_en_o, 1);
        trig_ext_i = 1;
        step();
        trig_ext_i = 0; eptr = (eptr + 1) % 64; estamp++;
        chk("R6 unselected ignored", state_o, 1);
        chk("R10 unselected not missed", miss_cnt_o, emiss);
        chk("R6 trig with write", wr_en_o, 1);
        trig_int_i = 1;
        step();
        trig_int_i = 0; eptr = (eptr + 1) % 64; estamp++; eev++;
        chk("R6 to convert", state_o, 2);
        chk("R6 event", event_id_o, eev);
        chk("R8 conv start", conv_start_o, 1);
        chk("R7 no write in convert", wr_en_o, 0);
        chk("R7 newest row", rd_row_o, ((eptr + 63) % 64) / 8);
        chk("R7 newest col", rd_col_o, ((eptr + 63) % 64) % 8);
        chk_ptr("R4 trigger write");
        step();
        chk("R8 conv start one cycle", conv_start_o, 0);
        chk("R8 hold convert", state_o, 2);
        trig_int_i = 1;
        step();
        trig_int_i = 0; emiss++;
        chk("R10 miss in convert", miss_cnt_o, emiss);
        chk("R6 no event when missed", event_id_o, eev);
        conv_done_i = 1;
        step();
        conv_done_i = 0;
        chk("R8 to readout", state_o, 3);
        step();
        chk("R9 hold readout", state_o, 3);
        rd_ack_i = 1;
        step();
        rd_ack_i = 0;
        chk("R9 to idle", state_o, 0);
    endtask

    task automatic test_ext_rearm();
        trig_mode_i = 1; rate_i = 0; start_i = 1;
        step();
        start_i = 0;
        trig_int_i = 1;
        step();
        trig_int_i = 0; eptr = (eptr + 1) % 64; estamp++;
        chk("R6 internal ignored in ext mode", state_o, 1);
        trig_ext_i = 1;
        step();
        trig_ext_i = 0; eptr = (eptr + 1) % 64; estamp++; eev++;
        chk("R6 ext to convert", state_o, 2);
        conv_done_i = 1;
        step();
        conv_done_i = 0;
        rd_ack_i = 1; rearm_i = 1;
        step();
        rd_ack_i = 0; rearm_i = 0;
        chk("R9 rearm to acquire", state_o, 1);
        chk("R11 no cal pulse", cal_pulse_o, 0);
        chk("R3 write after rearm", wr_en_o, 1);
        trig_ext_i = 1; stop_i = 1;
        step();
        trig_ext_i = 0; stop_i = 0; eptr = (eptr + 1) % 64; estamp++; eev++;
        chk("R12 trigger beats stop", state_o, 2);
        chk("R12 event counted", event_id_o, eev);
        chk_ptr("R4 ext mode");
        conv_done_i = 1;
        step();
        conv_done_i = 0; rd_ack_i = 1;
        step();
        rd_ack_i = 0;
        chk("R9 back to idle", state_o, 0);
    endtask

    task automatic test_wrap();
        trig_mode_i = 0; rate_i = 0; start_i = 1;
        step();
        start_i = 0;
        for (int k = 0; k < 70; k++) begin
            chk("R3 every cycle", wr_en_o, 1);
            step();
            eptr = (eptr + 1) % 64; estamp++;
            chk_ptr("R4 wrap walk");
        end
        stop_i = 1;
        step();
        stop_i = 0; eptr = (eptr + 1) % 64; estamp++;
        chk("R2 stop", state_o, 0);
        chk_ptr("R2 stop cycle write completes");
    endtask

    task automatic test_miss_sat();
        trig_mode_i = 0;
        for (int k = 0; k < 20; k++) begin
            trig_int_i = 1;
            step();
            trig_int_i = 0;
            step();
            if (emiss < 15) emiss++;
        end
        chk("R10 saturate", miss_cnt_o, emiss);
        chk("R10 idle stays", state_o, 0);
        chk("R10 no event", event_id_o, eev);
    endtask

    task automatic test_event_wrap();
        trig_mode_i = 0; rate_i = 0; rearm_i = 0;
        while (eev < 256) begin
            start_i = 1;
            step();
            start_i = 0; trig_int_i = 1;
            step();
            trig_int_i = 0; eptr = (eptr + 1) % 64; estamp++; eev++;
            conv_done_i = 1;
            step();
            conv_done_i = 0; rd_ack_i = 1;
            step();
            rd_ack_i = 0;
        end
        chk("R6 event wrap", event_id_o, eev % 256);
        chk_ptr("R4 after many events");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        test_reset();
        test_rate_stop();
        test_int_trigger();
        test_ext_rearm();
        test_wrap();
        test_miss_sat();
        test_event_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule